// File: doc/BRIEF.md
# Thirty-Two-Bit Arithmetic and Logic Unit

This block is a purely combinational arithmetic and logic unit. It accepts two operand words and a five-bit operation code, and it returns a result word together with a flag that is high whenever that result is all zeros. It is intended to sit in the execute stage of a simple single-cycle processor datapath. There, the flag feeds the branch-on-equal decision.

Addition and subtraction share a single ripple chain of one-bit full-adder cells, written with gate operators only. For subtraction, the second operand is inverted and the chain's carry-in is forced high, which forms its two's complement. The signed less-than compare reuses the same subtraction. It takes the sign of the difference and corrects it with the signed-overflow condition, so that the compare stays right at the extremes of the number range.

Top module: `alu_core`

## Requirements
- R1: Operation code 5'b00000 drives the result with the bitwise AND of the two operands.
- R2: Operation code 5'b00001 drives the result with the bitwise OR of the two operands.
- R3: Operation code 5'b00010 drives the result with the sum of the operands, wrapped modulo 2^32.
- R4: Operation code 5'b00110 drives the result with the first operand minus the second, wrapped modulo 2^32.
- R5: Operation code 5'b00111 drives the result with 1 when the first operand is less than the second as signed two's-complement numbers, and with 0 otherwise. This holds at the range extremes, for example 0x80000000 against 1 and 0x7FFFFFFF against 0xFFFFFFFF.
- R6: Operation code 5'b01100 drives the result with the bitwise NOR of the two operands.
- R7: Every other operation code drives the result with zero.
- R8: The zero flag is 1 exactly when all 32 result bits are 0, for every operation code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 32 | First operand |
| b_i | input | 32 | Second operand |
| op_i | input | 5 | Operation select code |
| res_o | output | 32 | Result word |
| zero_o | output | 1 | High when the result word is all zeros |

## Verification
The result word and the zero flag are produced in the same evaluation, so every applied vector judges both outputs against a model held in the bench. The cases where both change together are provoked on purpose. Subtracting equal operands, adding a value to its negation, and a less-than compare that comes out false all give a zero result, and in each of them the flag must rise in the same sample. Undefined operation codes pair a forced-zero result with a raised flag. Signed compares at the range extremes check that the overflow correction of the less-than path agrees with the model.

// File: rtl/alu_core.sv
module alu_core #(
  parameter int W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [4:0]   op_i,
  output logic [W-1:0] res_o,
  output logic         zero_o
);
  localparam logic [4:0] OP_AND = 5'b00000;
  localparam logic [4:0] OP_OR  = 5'b00001;
  localparam logic [4:0] OP_ADD = 5'b00010;
  localparam logic [4:0] OP_SUB = 5'b00110;
  localparam logic [4:0] OP_SLT = 5'b00111;
  localparam logic [4:0] OP_NOR = 5'b01100;

  logic         neg_b;
  logic [W-1:0] b_eff;
  logic [W:0]   cy;
  logic [W-1:0] sum;
  logic         ovf;
  logic         less;

  assign neg_b = (op_i == OP_SUB) || (op_i == OP_SLT);
  assign b_eff = b_i ^ {W{neg_b}};
  assign cy[0] = neg_b;

  for (genvar i = 0; i < W; i++) begin : g_fa
    logic p;
    assign p         = a_i[i] ^ b_eff[i];
    assign sum[i]    = p ^ cy[i];
    assign cy[i+1]   = (a_i[i] & b_eff[i]) | (p & cy[i]);
  end

  assign ovf  = cy[W] ^ cy[W-1];
  assign less = sum[W-1] ^ ovf;

  always_comb begin
    case (op_i)
      OP_AND:  res_o = a_i & b_i;
      OP_OR:   res_o = a_i | b_i;
      OP_ADD:  res_o = sum;
      OP_SUB:  res_o = sum;
      OP_SLT:  res_o = {{(W-1){1'b0}}, less};
      OP_NOR:  res_o = ~(a_i | b_i);
      default: res_o = '0;
    endcase
  end

  assign zero_o = ~|res_o;
endmodule

// File: rtl/alu_core_chk.sv
module alu_core_chk #(
  parameter int W = 32
) (
  input logic [W-1:0] a_i,
  input logic [W-1:0] b_i,
  input logic [4:0]   op_i,
  input logic [W-1:0] res_o,
  input logic         zero_o
);
  logic known;
  assign known = (op_i == 5'b00000) || (op_i == 5'b00001) || (op_i == 5'b00010) ||
                 (op_i == 5'b00110) || (op_i == 5'b00111) || (op_i == 5'b01100);

  always_comb begin
    if (op_i == 5'b00000) p_and_r1: assert (res_o == (a_i & b_i)) else $error("r1 and");
    if (op_i == 5'b00001) p_or_r2:  assert (res_o == (a_i | b_i)) else $error("r2 or");
    if (op_i == 5'b00010) p_add_r3: assert (res_o == W'(a_i + b_i)) else $error("r3 add");
    if (op_i == 5'b00110) p_sub_r4: assert (res_o == W'(a_i - b_i)) else $error("r4 sub");
    if (op_i == 5'b00111) p_slt_r5: assert (res_o == {{(W-1){1'b0}}, ($signed(a_i) < $signed(b_i))})
      else $error("r5 slt");
    if (op_i == 5'b01100) p_nor_r6: assert (res_o == ~(a_i | b_i)) else $error("r6 nor");
    if (!known) p_undef_r7: assert (res_o == '0) else $error("r7 undefined code");
    p_zero_r8: assert (zero_o == (res_o == '0)) else $error("r8 zero flag");
  end
endmodule

bind alu_core alu_core_chk #(.W(W)) u_chk (
  .a_i(a_i), .b_i(b_i), .op_i(op_i), .res_o(res_o), .zero_o(zero_o)
);

// File: tb/sim_alu_core.sv
module sim_alu_core;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [31:0] a, b, r;
  logic [4:0]  op;
  logic        e;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  alu_core u0 (.a_i(a), .b_i(b), .op_i(op), .res_o(r), .zero_o(e));

  function automatic logic [31:0] model(input logic [4:0] o, input logic [31:0] x, input logic [31:0] y);
    case (o)
      5'b00000: return x & y;
      5'b00001: return x | y;
      5'b00010: return x + y;
      5'b00110: return x - y;
      5'b00111: return ($signed(x) < $signed(y)) ? 32'd1 : 32'd0;
      5'b01100: return ~(x | y);
      default:  return 32'd0;
    endcase
  endfunction

  task automatic apply(input string tag, input logic [4:0] o, input logic [31:0] x, input logic [31:0] y);
    logic [31:0] exp_r;
    @(negedge clk);
    op = o; a = x; b = y;
    #2;
    exp_r = model(o, x, y);
    n_chk++;
    if (r !== exp_r) begin
      n_bad++;
      $display("FAIL %s op=%b a=%h b=%h result actual=%h expected=%h", tag, o, x, y, r, exp_r);
    end
    n_chk++;
    if (e !== (exp_r == 32'd0)) begin
      n_bad++;
      $display("FAIL R8 op=%b a=%h b=%h zero actual=%b expected=%b", o, x, y, e, (exp_r == 32'd0));
    end
  endtask

  task automatic t_reset_state();
    apply("R1", 5'b00000, 32'd0, 32'd0);
  endtask

  task automatic t_logic();
    apply("R1", 5'b00000, 32'hF0F0_1234, 32'h0FF0_FFFF);
    apply("R1", 5'b00000, 32'hAAAA_AAAA, 32'h5555_5555);
    apply("R2", 5'b00001, 32'hF000_0001, 32'h0000_1000);
    apply("R2", 5'b00001, 32'd0, 32'd0);
    apply("R6", 5'b01100, 32'hFFFF_0000, 32'h0000_00FF);
    apply("R6", 5'b01100, 32'hFFFF_0000, 32'h0000_FFFF);
  endtask

  task automatic t_arith();
    apply("R3", 5'b00010, 32'd5, 32'd4);
    apply("R3", 5'b00010, 32'hFFFF_FFFF, 32'd1);
    apply("R3", 5'b00010, 32'h7FFF_FFFF, 32'd1);
    apply("R3", 5'b00010, 32'd1234, 32'hFFFF_FB2E);
    apply("R4", 5'b00110, 32'd9, 32'd9);
    apply("R4", 5'b00110, 32'd0, 32'd1);
    apply("R4", 5'b00110, 32'h8000_0000, 32'd1);
  endtask

  task automatic t_slt();
    apply("R5", 5'b00111, 32'h8000_0000, 32'd1);
    apply("R5", 5'b00111, 32'd1, 32'h8000_0000);
    apply("R5", 5'b00111, 32'h7FFF_FFFF, 32'hFFFF_FFFF);
    apply("R5", 5'b00111, 32'hFFFF_FFFF, 32'h7FFF_FFFF);
    apply("R5", 5'b00111, 32'd3, 32'd3);
    apply("R5", 5'b00111, 32'hFFFF_FFFE, 32'hFFFF_FFFF);
  endtask

  task automatic t_undef();
    apply("R7", 5'b00011, 32'hDEAD_BEEF, 32'h1234_5678);
    apply("R7", 5'b11111, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    apply("R7", 5'b00100, 32'h0000_0001, 32'h0000_0001);
    apply("R7", 5'b01101, 32'hCAFE_0000, 32'd7);
  endtask

  task automatic t_random();
    logic [4:0] codes [6] = '{5'b00000, 5'b00001, 5'b00010, 5'b00110, 5'b00111, 5'b01100};
    string tags [6] = '{"R1", "R2", "R3", "R4", "R5", "R6"};
    for (int i = 0; i < 600; i++) begin
      int k = i % 6;
      logic [31:0] x = $urandom();
      logic [31:0] y = (i % 7 == 0) ? x : $urandom();
      apply(tags[k], codes[k], x, y);
    end
  endtask

  initial begin
    op = 5'b00000; a = '0; b = '0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    t_reset_state();
    t_logic();
    t_arith();
    t_slt();
    t_undef();
    t_random();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (50000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule